// File: doc/BRIEF.md
# Dual-Rail Start-Up Sequencer with Latched Short Supervisor

This block brings up a positive boost converter and a negative inverting converter in a fixed order. It also watches both rails for shorts. When the enable rises, the boost stage starts at once with its current limit held low. After a first window (8 ms by default) the inverting stage is released at its default setting. Comparator flags are sampled at the end of the first window and again at the end of a second window (16 ms), and either check can stop the start-up.

Once the block is running, a debounce counter for each rail watches for a short. If a rail stays past its short threshold for 3 ms without a break, the block shuts both converters off and latches the fault. Only an undervoltage lockout or an enable low-then-high sequence releases the latch. An over-temperature flag also shuts both converters off, but nothing is latched, and start-up begins again once the flag clears. All timing is counted in clock cycles, scaled by a cycles-per-millisecond parameter.

Top module: `rail_sequencer`

## Requirements
- R1: While reset is high, and on the first edge after it, boost_en_o, soft_start_o, inv_en_o and fault_o are all 0.
- R2: Take the first clock edge that samples en_i=1 with uvlo_i=0 and tsd_i=0 while the block is off. On that edge boost_en_o=1 and soft_start_o=1, while inv_en_o and fault_o stay 0.
- R3: inv_en_o rises exactly SEQ_MS*CYC_PER_MS edges after boost_en_o rises, and soft_start_o falls on that same edge.
- R4: If pos_reg_ok_i=0 on the edge that ends the first window, fault_o=1 on that edge and both converter enables go to 0.
- R5: If neg_above_start_thr_i=1 on the edge that ends the first window, a fault is declared in the same way.
- R6: neg_reg_ok_i is sampled only on the edge that is REG_MS*CYC_PER_MS edges after boost_en_o rises. A 0 on that edge declares a fault. A 1 on that edge enters running operation with both enables held. A 0 earlier in the window has no effect.
- R7: In running operation, pos_above_short_i=0 on DEB_MS*CYC_PER_MS consecutive edges declares a fault on the last of those edges. Any single edge with the flag back at 1 restarts the count.
- R8: In running operation, neg_above_run_thr_i=1 on DEB_MS*CYC_PER_MS consecutive edges declares a fault in the same way.
- R9: While fault_o=1, both enables stay 0. The fault stays latched while en_i=1 and uvlo_i=0, even after the cause clears, and tsd_i does not release it.
- R10: en_i=0 or uvlo_i=1 clears fault_o and both enables on the next edge. A later en_i=1 then starts again as in R2.
- R11: tsd_i=1 drives both enables to 0 on the next edge without setting fault_o. When tsd_i returns to 0 with en_i=1, start-up repeats from the boost stage, with full R3 timing.
- R12: While uvlo_i=1, the converters stay off even with en_i=1. Start-up begins on the first edge after uvlo_i falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Enable from the control-pin decoder |
| uvlo_i | input | 1 | Input undervoltage lockout active |
| tsd_i | input | 1 | Over-temperature shutdown active |
| pos_reg_ok_i | input | 1 | Positive rail in regulation |
| pos_above_short_i | input | 1 | Positive rail above its short threshold |
| neg_above_start_thr_i | input | 1 | Negative rail above its start-up short threshold (bad) |
| neg_above_run_thr_i | input | 1 | Negative rail above its run short threshold (bad) |
| neg_reg_ok_i | input | 1 | Negative rail in regulation |
| boost_en_o | output | 1 | Boost converter enable |
| soft_start_o | output | 1 | Reduced switch current limit for the boost stage |
| inv_en_o | output | 1 | Inverting converter enable |
| fault_o | output | 1 | Latched short fault |

## Verification
The bench checks the window boundaries to the exact cycle. It looks for the inverting enable one cycle early or late, and for a regulation check that is sampled continuously instead of only at the window edge; a design with that error would fault on a harmless early dip of the negative rail. It breaks a run-time short one cycle before the debounce limit, which catches a counter that fails to clear and so trips on intermittent glitches. It also targets latch release. A design that let over-temperature, or the rail simply recovering, clear the fault would restart the converters on its own. A design that did not restart after an enable toggle or a lockout would stay dark.

// File: rtl/rail_seq_pkg.sv
package rail_seq_pkg;

    localparam int NUM_MON = 2;
    localparam int MON_POS = 0;
    localparam int MON_NEG = 1;

    typedef enum logic [2:0] {
        ST_OFF   = 3'd0,
        ST_BOOST = 3'd1,
        ST_BOTH  = 3'd2,
        ST_RUN   = 3'd3,
        ST_FAULT = 3'd4
    } sup_state_t;

    typedef struct packed {
        logic boost_en;
        logic soft_start;
        logic inv_en;
        logic fault;
    } drive_t;

    function automatic drive_t drive_of(sup_state_t s);
        drive_t d;
        d.boost_en   = (s == ST_BOOST) || (s == ST_BOTH) || (s == ST_RUN);
        d.soft_start = (s == ST_BOOST);
        d.inv_en     = (s == ST_BOTH) || (s == ST_RUN);
        d.fault      = (s == ST_FAULT);
        return d;
    endfunction

    function automatic logic in_window(sup_state_t s);
        return (s == ST_BOOST) || (s == ST_BOTH);
    endfunction

endpackage

// File: rtl/rail_seq_timer.sv
module rail_seq_timer #(
    parameter int SEQ_CYC = 8000,
    parameter int REG_CYC = 16000
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    output logic hit_seq_o,
    output logic hit_reg_o
);
    localparam int CW = $clog2(REG_CYC + 1);
    localparam logic [CW-1:0] SEQ_LAST = CW'(SEQ_CYC - 1);
    localparam logic [CW-1:0] REG_LAST = CW'(REG_CYC - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run_i) begin
            cnt <= '0;
        end else if (cnt != REG_LAST) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign hit_seq_o = run_i && (cnt == SEQ_LAST);
    assign hit_reg_o = run_i && (cnt == REG_LAST);

endmodule

// File: rtl/rail_seq_debounce.sv
module rail_seq_debounce #(
    parameter int LIMIT = 3000
) (
    input  logic clk,
    input  logic rst,
    input  logic arm_i,
    input  logic cond_i,
    output logic trip_o
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !arm_i || !cond_i) begin
            cnt <= '0;
        end else if (cnt != LAST) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign trip_o = arm_i && cond_i && (cnt == LAST);

endmodule

// File: rtl/rail_sequencer.sv
module rail_sequencer
    import rail_seq_pkg::*;
#(
    parameter int CYC_PER_MS = 1000,
    parameter int SEQ_MS     = 8,
    parameter int REG_MS     = 16,
    parameter int DEB_MS     = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic en_i,
    input  logic uvlo_i,
    input  logic tsd_i,
    input  logic pos_reg_ok_i,
    input  logic pos_above_short_i,
    input  logic neg_above_start_thr_i,
    input  logic neg_above_run_thr_i,
    input  logic neg_reg_ok_i,
    output logic boost_en_o,
    output logic soft_start_o,
    output logic inv_en_o,
    output logic fault_o
);
    localparam int SEQ_CYC = SEQ_MS * CYC_PER_MS;
    localparam int REG_CYC = REG_MS * CYC_PER_MS;
    localparam int DEB_CYC = DEB_MS * CYC_PER_MS;

    sup_state_t st, st_nx;
    drive_t     drv_q;
    logic       hit_seq, hit_reg;
    logic       in_run;
    logic [NUM_MON-1:0] mon_bad;
    logic [NUM_MON-1:0] mon_trip;

    rail_seq_timer #(
        .SEQ_CYC(SEQ_CYC),
        .REG_CYC(REG_CYC)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .run_i    (in_window(st)),
        .hit_seq_o(hit_seq),
        .hit_reg_o(hit_reg)
    );

    assign in_run            = (st == ST_RUN);
    assign mon_bad[MON_POS]  = ~pos_above_short_i;
    assign mon_bad[MON_NEG]  = neg_above_run_thr_i;

    for (genvar g = 0; g < NUM_MON; g++) begin : g_mon
        rail_seq_debounce #(
            .LIMIT(DEB_CYC)
        ) u_deb (
            .clk   (clk),
            .rst   (rst),
            .arm_i (in_run),
            .cond_i(mon_bad[g]),
            .trip_o(mon_trip[g])
        );
    end

    always_comb begin
        st_nx = st;
        if (uvlo_i || !en_i) begin
            st_nx = ST_OFF;
        end else if (st == ST_FAULT) begin
            st_nx = ST_FAULT;
        end else if (tsd_i) begin
            st_nx = ST_OFF;
        end else begin
            unique case (st)
                ST_OFF:   st_nx = ST_BOOST;
                ST_BOOST: begin
                    if (hit_seq) begin
                        st_nx = (!pos_reg_ok_i || neg_above_start_thr_i) ? ST_FAULT : ST_BOTH;
                    end
                end
                ST_BOTH: begin
                    if (hit_reg) begin
                        st_nx = neg_reg_ok_i ? ST_RUN : ST_FAULT;
                    end
                end
                ST_RUN: begin
                    if (|mon_trip) begin
                        st_nx = ST_FAULT;
                    end
                end
                default:  st_nx = ST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= ST_OFF;
            drv_q <= '0;
        end else begin
            st    <= st_nx;
            drv_q <= drive_of(st_nx);
        end
    end

    assign boost_en_o   = drv_q.boost_en;
    assign soft_start_o = drv_q.soft_start;
    assign inv_en_o     = drv_q.inv_en;
    assign fault_o      = drv_q.fault;

endmodule

// File: rtl/rail_seq_checker.sv
module rail_seq_checker (
    input logic clk,
    input logic rst,
    input logic en_i,
    input logic uvlo_i,
    input logic tsd_i,
    input logic boost_en_o,
    input logic soft_start_o,
    input logic inv_en_o,
    input logic fault_o
);
    a_r2_boost_starts_alone: assert property (@(posedge clk) disable iff (rst)
        $rose(boost_en_o) |-> (soft_start_o && !inv_en_o && !fault_o));

    a_r3_inv_needs_boost: assert property (@(posedge clk) disable iff (rst)
        inv_en_o |-> (boost_en_o && !soft_start_o));

    a_r3_inv_after_soft: assert property (@(posedge clk) disable iff (rst)
        $rose(inv_en_o) |-> $past(soft_start_o));

    a_r9_fault_kills_rails: assert property (@(posedge clk) disable iff (rst)
        fault_o |-> (!boost_en_o && !inv_en_o));

    a_r9_fault_held: assert property (@(posedge clk) disable iff (rst)
        (fault_o && en_i && !uvlo_i) |=> fault_o);

    a_r10_clear_on_off: assert property (@(posedge clk) disable iff (rst)
        (!en_i || uvlo_i) |=> (!fault_o && !boost_en_o && !inv_en_o));

    a_r11_tsd_off: assert property (@(posedge clk) disable iff (rst)
        tsd_i |=> (!boost_en_o && !inv_en_o));
endmodule

bind rail_sequencer rail_seq_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .en_i        (en_i),
    .uvlo_i      (uvlo_i),
    .tsd_i       (tsd_i),
    .boost_en_o  (boost_en_o),
    .soft_start_o(soft_start_o),
    .inv_en_o    (inv_en_o),
    .fault_o     (fault_o)
);

// File: tb/rail_sequencer_bench.sv
module rail_sequencer_bench;
    localparam int CPM   = 4;
    localparam int T_SEQ = 8 * CPM;
    localparam int T_REG = 16 * CPM;
    localparam int T_DEB = 3 * CPM;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en_i = 1'b0, uvlo_i = 1'b0, tsd_i = 1'b0;
    logic pos_reg_ok_i, pos_above_short_i, neg_above_start_thr_i;
    logic neg_above_run_thr_i, neg_reg_ok_i;
    logic boost_en_o, soft_start_o, inv_en_o, fault_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    rail_sequencer #(.CYC_PER_MS(CPM)) u_rail_sequencer (
        .clk(clk), .rst(rst), .en_i(en_i), .uvlo_i(uvlo_i), .tsd_i(tsd_i),
        .pos_reg_ok_i(pos_reg_ok_i), .pos_above_short_i(pos_above_short_i),
        .neg_above_start_thr_i(neg_above_start_thr_i),
        .neg_above_run_thr_i(neg_above_run_thr_i), .neg_reg_ok_i(neg_reg_ok_i),
        .boost_en_o(boost_en_o), .soft_start_o(soft_start_o),
        .inv_en_o(inv_en_o), .fault_o(fault_o)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic good_flags();
        pos_reg_ok_i = 1'b1; pos_above_short_i = 1'b1;
        neg_above_start_thr_i = 1'b0; neg_above_run_thr_i = 1'b0;
        neg_reg_ok_i = 1'b1;
    endtask

    task automatic go_off();
        en_i = 1'b0; tsd_i = 1'b0; uvlo_i = 1'b0;
        step(2);
        good_flags();
    endtask

    task automatic bring_up();
        en_i = 1'b1;
        step(T_REG + 1);
    endtask

    task automatic t_reset();
        good_flags();
        step(3);
        chk("R1 boost in reset", boost_en_o, 1'b0);
        chk("R1 fault in reset", fault_o, 1'b0);
        rst = 1'b0;
        step(1);
        chk("R1 boost after reset", boost_en_o, 1'b0);
        chk("R1 inv after reset", inv_en_o, 1'b0);
        chk("R1 soft after reset", soft_start_o, 1'b0);
    endtask

    task automatic t_normal_start();
        en_i = 1'b1;
        step(1);
        chk("R2 boost on", boost_en_o, 1'b1);
        chk("R2 soft on", soft_start_o, 1'b1);
        chk("R2 inv off", inv_en_o, 1'b0);
        step(T_SEQ - 1);
        chk("R3 inv not early", inv_en_o, 1'b0);
        chk("R3 soft still on", soft_start_o, 1'b1);
        step(1);
        chk("R3 inv on at window", inv_en_o, 1'b1);
        chk("R3 soft off at window", soft_start_o, 1'b0);
        step(T_REG - T_SEQ);
        chk("R6 run no fault", fault_o, 1'b0);
        step(50);
        chk("R6 run boost held", boost_en_o, 1'b1);
        chk("R6 run inv held", inv_en_o, 1'b1);
        go_off();
        chk("R10 off after en low", boost_en_o, 1'b0);
    endtask

    task automatic t_pos_not_ok();
        pos_reg_ok_i = 1'b0;
        en_i = 1'b1;
        step(T_SEQ);
        chk("R4 no fault before window", fault_o, 1'b0);
        step(1);
        chk("R4 fault at window", fault_o, 1'b1);
        chk("R4 boost off", boost_en_o, 1'b0);
        chk("R4 inv off", inv_en_o, 1'b0);
        go_off();
    endtask

    task automatic t_neg_start_short();
        neg_above_start_thr_i = 1'b1;
        en_i = 1'b1;
        step(T_SEQ);
        chk("R5 no fault before window", fault_o, 1'b0);
        step(1);
        chk("R5 fault at window", fault_o, 1'b1);
        chk("R5 inv never on", inv_en_o, 1'b0);
        go_off();
    endtask

    task automatic t_neg_not_reg();
        neg_reg_ok_i = 1'b0;
        en_i = 1'b1;
        step(T_SEQ + 1);
        chk("R6 early dip ignored at first window", inv_en_o, 1'b1);
        step(T_REG - T_SEQ - 1);
        chk("R6 no fault before second window", fault_o, 1'b0);
        step(1);
        chk("R6 fault at second window", fault_o, 1'b1);
        go_off();
        neg_reg_ok_i = 1'b0;
        en_i = 1'b1;
        step(T_SEQ + 1);
        neg_reg_ok_i = 1'b1;
        step(T_REG - T_SEQ);
        chk("R6 recovered before window no fault", fault_o, 1'b0);
        chk("R6 recovered run inv", inv_en_o, 1'b1);
        go_off();
    endtask

    task automatic t_pos_short_run();
        bring_up();
        pos_above_short_i = 1'b0;
        step(T_DEB - 1);
        pos_above_short_i = 1'b1;
        step(1);
        pos_above_short_i = 1'b0;
        step(T_DEB - 1);
        chk("R7 interrupted short no fault", fault_o, 1'b0);
        step(1);
        chk("R7 continuous short faults", fault_o, 1'b1);
        chk("R7 boost off", boost_en_o, 1'b0);
        go_off();
    endtask

    task automatic t_latch_and_toggle();
        bring_up();
        neg_above_run_thr_i = 1'b1;
        step(T_DEB - 1);
        chk("R8 no fault before limit", fault_o, 1'b0);
        step(1);
        chk("R8 neg short faults", fault_o, 1'b1);
        neg_above_run_thr_i = 1'b0;
        step(3);
        chk("R9 fault held after cause gone", fault_o, 1'b1);
        tsd_i = 1'b1;
        step(2);
        tsd_i = 1'b0;
        step(2);
        chk("R9 tsd does not clear fault", fault_o, 1'b1);
        chk("R9 boost stays off", boost_en_o, 1'b0);
        en_i = 1'b0;
        step(1);
        chk("R10 en low clears fault", fault_o, 1'b0);
        en_i = 1'b1;
        step(1);
        chk("R10 restart boost", boost_en_o, 1'b1);
        chk("R10 restart soft", soft_start_o, 1'b1);
        go_off();
    endtask

    task automatic t_uvlo();
        bring_up();
        neg_above_run_thr_i = 1'b1;
        step(T_DEB);
        chk("R8 fault before lockout", fault_o, 1'b1);
        neg_above_run_thr_i = 1'b0;
        uvlo_i = 1'b1;
        step(1);
        chk("R10 lockout clears fault", fault_o, 1'b0);
        step(5);
        chk("R12 held off in lockout", boost_en_o, 1'b0);
        uvlo_i = 1'b0;
        step(1);
        chk("R12 start after lockout", boost_en_o, 1'b1);
        chk("R12 soft after lockout", soft_start_o, 1'b1);
        go_off();
    endtask

    task automatic t_tsd();
        bring_up();
        tsd_i = 1'b1;
        step(1);
        chk("R11 boost off", boost_en_o, 1'b0);
        chk("R11 inv off", inv_en_o, 1'b0);
        chk("R11 no fault", fault_o, 1'b0);
        step(T_REG);
        chk("R11 stays off", boost_en_o, 1'b0);
        tsd_i = 1'b0;
        step(1);
        chk("R11 restart boost", boost_en_o, 1'b1);
        chk("R11 restart inv off", inv_en_o, 1'b0);
        step(T_SEQ - 1);
        chk("R11 inv not early", inv_en_o, 1'b0);
        step(1);
        chk("R11 inv at window", inv_en_o, 1'b1);
        go_off();
    endtask

    initial begin
        t_reset();
        t_normal_start();
        t_pos_not_ok();
        t_neg_start_short();
        t_neg_not_reg();
        t_pos_short_run();
        t_latch_and_toggle();
        t_uvlo();
        t_tsd();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule